// File: doc/BRIEF.md
# Time-multiplexed ADSR envelope generator

This block computes the attenuation envelope for a bank of synthesis operators. The default bank has 24 operators. One shared update datapath serves all of them in turn: every third clock it reads one operator's state from a small register file, advances that operator by one envelope step, and writes the result back. A free-running envelope counter increments each time the last operator has been visited. The counter sets how often each operator is actually updated, and which step of an 8-step increment pattern it uses.

Each operator runs through four phases: attack, decay, sustain and release. It takes its rates, sustain level, key-scale setting and keycode from a per-operator configuration word. A write port loads the whole word in one cycle. A separate event port starts (key-on) or stops (key-off) a note on one operator. A combinational read port returns the current attenuation and phase of any operator. The value 1023 means silent.

Top module: `eg_core`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every operator reads back attenuation 1023 and phase 3. Phase codes are 0 attack, 1 decay, 2 sustain and 3 release.
- R2: The effective rate for a programmed rate R is 0 when R is 0. Otherwise it is 2*R + (kc >> (3 - ks)), limited to 63. For release, R is 2*rr + 1.
- R3: For an effective rate below 48 the gate shift is (47 - rate) >> 2; otherwise it is 0. A visit changes the attenuation only when the low shift bits of the envelope counter are all zero. The step index is (counter >> shift) & 7.
- R4: The increment is 0 for rates 0 and 1, and 8 for rates 60 to 63. Rates 48 to 59 use the pattern chosen by rate mod 4 (mod 0: all 1; mod 1: 2 at steps 3 and 7; mod 2: 2 at odd steps; mod 3: 2 at steps 1,2,3,5,6,7; 1 elsewhere), shifted left by (rate - 48) >> 2. Rates 8 to 47 use a 0/1 pattern chosen by rate mod 4 (mod 0: 1 at odd steps; mod 1: 1 at steps 1,3,4,5,7; mod 2: 1 at steps 1,2,3,5,6,7; mod 3: 1 at steps 1 to 7). Rates 2 to 5 use the mod-0 pattern and rates 6 and 7 use the mod-2 pattern.
- R5: On an updating visit in attack, the attenuation drops by ceil((att + 1) * inc / 16). A drop that reaches or passes 0 gives attenuation 0 and moves the operator to decay.
- R6: A decay operator whose attenuation is at or above its sustain level moves to sustain before its step is taken. The sustain level is sl*32, except that sl = 15 gives 1023. In decay, sustain and release, the step adds the increment and saturates at 1023.
- R7: A key-on with an effective attack rate of 62 or more sets attenuation 0 and phase decay. Any other key-on sets phase attack and leaves the attenuation unchanged.
- R8: A key-off sets phase release and leaves the attenuation unchanged. Release then advances at rate 2*rr + 1.
- R9: When a key event targets the operator visited in the same cycle, the key event alone decides that operator's next state, and the visit's step is dropped.
- R10: Operator k is visited at clock edge 3*k + 72*n after reset release, counting the first edge with rst_n high as edge 0. The envelope counter increments on the edge that visits the last operator.
- R11: A configuration write takes effect at its clock edge. Reset clears every configuration word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load configuration word of operator cfg_op |
| cfg_op | input | 5 | Operator index for configuration write |
| cfg_ar | input | 5 | Attack rate |
| cfg_dr | input | 5 | Decay rate |
| cfg_sr | input | 5 | Sustain-phase rate |
| cfg_rr | input | 4 | Release rate field |
| cfg_sl | input | 4 | Sustain level field |
| cfg_ks | input | 2 | Key-scale setting |
| cfg_kc | input | 5 | Keycode of the operator's channel |
| key_we | input | 1 | Key event strobe |
| key_op | input | 5 | Operator index for key event |
| key_on | input | 1 | 1 key-on, 0 key-off |
| rd_op | input | 5 | Operator index for readback |
| rd_att | output | 10 | Attenuation of rd_op (1023 silent) |
| rd_phase | output | 2 | Phase of rd_op |

## Verification
The collision of interest is a key event and a scheduled envelope visit that land on the same operator in the same cycle. The bench tracks the visit schedule from reset. It issues a key-off exactly on the edge that visits an operator climbing by 8 per visit, and expects phase 3 with the attenuation read just before the edge, not that value plus 8. A random phase fires key events and configuration writes at every slot alignment. A reference model applies the visit first and lets the key event overwrite it. The model is compared on every cycle.

// File: rtl/eg_pkg.sv
// Shared types and the effective-rate function for the envelope generator.
// Assumes a 10-bit attenuation in which all ones means silent.
package eg_pkg;
    localparam int ATT_W = 10;
    localparam logic [ATT_W-1:0] ATT_MAX = '1;

    typedef enum logic [1:0] {
        PH_ATTACK  = 2'd0,
        PH_DECAY   = 2'd1,
        PH_SUSTAIN = 2'd2,
        PH_RELEASE = 2'd3
    } eg_phase_e;

    typedef struct packed {
        logic [4:0] ar;
        logic [4:0] dr;
        logic [4:0] sr;
        logic [3:0] rr;
        logic [3:0] sl;
        logic [1:0] ks;
        logic [4:0] kc;
    } eg_cfg_t;

    // Key-scaled effective rate: 0 stays 0, else 2R plus scaled keycode, capped at 63.
    function automatic logic [5:0] eg_eff_rate(input logic [4:0] r,
                                               input logic [4:0] kc,
                                               input logic [1:0] ks);
        logic [6:0] sum;
        if (r == 5'd0) return 6'd0;
        sum = 7'({r, 1'b0}) + 7'(kc >> (2'd3 - ks));
        return (sum > 7'd63) ? 6'd63 : sum[5:0];
    endfunction
endpackage

// File: rtl/eg_seq.sv
// Slot sequencer: raises visit once every SLOT_DIV clocks, walks the operator
// index through 0..NUM_OPS-1 and bumps the envelope counter after the last one.
// Assumes SLOT_DIV >= 2.
module eg_seq #(
    parameter int NUM_OPS  = 24,
    parameter int SLOT_DIV = 3,
    parameter int CNT_W    = 16,
    localparam int OP_W    = $clog2(NUM_OPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             visit,
    output logic [OP_W-1:0]  op_idx,
    output logic [CNT_W-1:0] env_cnt
);
    localparam int DIV_W = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;

    logic [DIV_W-1:0] div_q;

    assign visit = (div_q == '0);

    // Advance the slot divider, operator index and envelope counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            op_idx  <= '0;
            env_cnt <= '0;
        end else begin
            div_q <= (div_q == DIV_W'(SLOT_DIV - 1)) ? '0 : div_q + 1'b1;
            if (visit) begin
                if (op_idx == OP_W'(NUM_OPS - 1)) begin
                    op_idx  <= '0;
                    env_cnt <= env_cnt + 1'b1;
                end else begin
                    op_idx <= op_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/eg_inc_gen.sv
// Update gate and increment lookup for one effective rate: derives the counter
// shift, decides whether this visit updates, and picks the 8-step increment.
// Purely combinational.
module eg_inc_gen #(
    parameter int CNT_W = 16
) (
    input  logic [5:0]       eff,
    input  logic [CNT_W-1:0] cnt,
    output logic             go,
    output logic [3:0]       inc
);
    // Row r occupies bits [8r+7:8r]; bit s is the value at step s.
    localparam logic [31:0] LOW_ROWS = {8'hFE, 8'hEE, 8'hBA, 8'hAA};
    localparam logic [31:0] TOP_XTRA = {8'hEE, 8'hAA, 8'h88, 8'h00};

    logic [3:0]       shift;
    logic [CNT_W-1:0] mask;
    logic [2:0]       step;
    logic [1:0]       row;

    // Gate: update only when the low shift bits of the counter are zero.
    always_comb begin
        shift = (eff < 6'd48) ? 4'((6'd47 - eff) >> 2) : 4'd0;
        mask  = (CNT_W'(1) << shift) - CNT_W'(1);
        go    = ((cnt & mask) == '0);
        step  = 3'(cnt >> shift);
    end

    // Increment: flat ends, low-rate 0/1 patterns, top-end 1/2 patterns shifted.
    always_comb begin
        row = eff[1:0];
        if (eff < 6'd2) begin
            inc = 4'd0;
        end else if (eff >= 6'd60) begin
            inc = 4'd8;
        end else if (eff < 6'd8) begin
            inc = {3'b0, LOW_ROWS[{(eff[2:1] == 2'b11) ? 2'd2 : 2'd0, step}]};
        end else if (eff < 6'd48) begin
            inc = {3'b0, LOW_ROWS[{row, step}]};
        end else begin
            inc = (4'd1 + {3'b0, TOP_XTRA[{row, step}]}) << 2'((eff - 6'd48) >> 2);
        end
    end
endmodule

// File: rtl/eg_step.sv
// Next-state logic for the visited operator: handles the decay-to-sustain
// handover, selects the rate for the phase, and applies the attack or additive step.
// Purely combinational.
module eg_step
    import eg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  eg_phase_e        phase_i,
    input  logic [ATT_W-1:0] att_i,
    input  eg_cfg_t          cfg,
    input  logic [CNT_W-1:0] cnt,
    output eg_phase_e        phase_o,
    output logic [ATT_W-1:0] att_o
);
    eg_phase_e        ph0;
    logic [ATT_W-1:0] sl_full;
    logic [4:0]       r_prog;
    logic [5:0]       eff;
    logic             go;
    logic [3:0]       inc;
    logic [14:0]      prod;
    logic [10:0]      dec;
    logic [ATT_W:0]   sum;

    // Phase handover and rate choice.
    always_comb begin
        sl_full = (cfg.sl == 4'hF) ? ATT_MAX : {1'b0, cfg.sl, 5'b0};
        ph0 = (phase_i == PH_DECAY && att_i >= sl_full) ? PH_SUSTAIN : phase_i;
        case (ph0)
            PH_ATTACK:  r_prog = cfg.ar;
            PH_DECAY:   r_prog = cfg.dr;
            PH_SUSTAIN: r_prog = cfg.sr;
            default:    r_prog = {cfg.rr, 1'b1};
        endcase
        eff = eg_eff_rate(r_prog, cfg.kc, cfg.ks);
    end

    eg_inc_gen #(.CNT_W(CNT_W)) u_inc (
        .eff (eff),
        .cnt (cnt),
        .go  (go),
        .inc (inc)
    );

    // Apply the step: exponential drop in attack, saturating climb otherwise.
    always_comb begin
        prod    = (15'(att_i) + 15'd1) * 15'(inc);
        dec     = 11'((prod + 15'd15) >> 4);
        sum     = {1'b0, att_i} + (ATT_W+1)'(inc);
        phase_o = ph0;
        att_o   = att_i;
        if (go) begin
            if (ph0 == PH_ATTACK) begin
                if (dec >= 11'(att_i)) begin
                    att_o   = '0;
                    phase_o = PH_DECAY;
                end else begin
                    att_o = att_i - ATT_W'(dec);
                end
            end else begin
                att_o = (sum > (ATT_W+1)'(ATT_MAX)) ? ATT_MAX : sum[ATT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/eg_core.sv
// Time-multiplexed envelope generator top. It holds per-operator state and
// configuration in flip-flops, updates one operator per visit slot, and applies
// key events and configuration writes. A key event overrides a same-cycle visit
// to the same operator. Assumes indices on the write ports are < NUM_OPS.
module eg_core
    import eg_pkg::*;
#(
    parameter int NUM_OPS  = 24,
    parameter int SLOT_DIV = 3,
    parameter int CNT_W    = 16,
    localparam int OP_W    = $clog2(NUM_OPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [OP_W-1:0]  cfg_op,
    input  logic [4:0]       cfg_ar,
    input  logic [4:0]       cfg_dr,
    input  logic [4:0]       cfg_sr,
    input  logic [3:0]       cfg_rr,
    input  logic [3:0]       cfg_sl,
    input  logic [1:0]       cfg_ks,
    input  logic [4:0]       cfg_kc,
    input  logic             key_we,
    input  logic [OP_W-1:0]  key_op,
    input  logic             key_on,
    input  logic [OP_W-1:0]  rd_op,
    output logic [ATT_W-1:0] rd_att,
    output logic [1:0]       rd_phase
);
    logic                          visit;
    logic [OP_W-1:0]               op_idx;
    logic [CNT_W-1:0]              env_cnt;
    logic [NUM_OPS-1:0][ATT_W-1:0] att_q;
    logic [NUM_OPS-1:0][1:0]       ph_q;
    eg_cfg_t                       cfg_q [NUM_OPS];
    eg_cfg_t                       cfg_in;
    eg_phase_e                     nx_ph;
    logic [ATT_W-1:0]              nx_att;
    logic                          key_hit;
    logic                          cfg_hit;
    logic                          key_fast;

    eg_seq #(.NUM_OPS(NUM_OPS), .SLOT_DIV(SLOT_DIV), .CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .visit   (visit),
        .op_idx  (op_idx),
        .env_cnt (env_cnt)
    );

    eg_step #(.CNT_W(CNT_W)) u_step (
        .phase_i (eg_phase_e'(ph_q[op_idx])),
        .att_i   (att_q[op_idx]),
        .cfg     (cfg_q[op_idx]),
        .cnt     (env_cnt),
        .phase_o (nx_ph),
        .att_o   (nx_att)
    );

    // Decode write strobes and the key-on attack-skip condition.
    always_comb begin
        cfg_in   = '{ar: cfg_ar, dr: cfg_dr, sr: cfg_sr, rr: cfg_rr,
                     sl: cfg_sl, ks: cfg_ks, kc: cfg_kc};
        key_hit  = key_we && (int'(key_op) < NUM_OPS);
        cfg_hit  = cfg_we && (int'(cfg_op) < NUM_OPS);
        key_fast = eg_eff_rate(cfg_q[key_op].ar, cfg_q[key_op].kc,
                               cfg_q[key_op].ks) >= 6'd62;
    end

    // State write-back: visit first, key event last so that it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OPS; i++) begin
                att_q[i] <= ATT_MAX;
                ph_q[i]  <= PH_RELEASE;
                cfg_q[i] <= '0;
            end
        end else begin
            if (visit) begin
                att_q[op_idx] <= nx_att;
                ph_q[op_idx]  <= nx_ph;
            end
            if (key_hit) begin
                if (key_on && key_fast) begin
                    att_q[key_op] <= '0;
                    ph_q[key_op]  <= PH_DECAY;
                end else begin
                    att_q[key_op] <= att_q[key_op];
                    ph_q[key_op]  <= key_on ? PH_ATTACK : PH_RELEASE;
                end
            end
            if (cfg_hit) cfg_q[cfg_op] <= cfg_in;
        end
    end

    // Readback port.
    always_comb begin
        rd_att   = (int'(rd_op) < NUM_OPS) ? att_q[rd_op] : '0;
        rd_phase = (int'(rd_op) < NUM_OPS) ? ph_q[rd_op]  : 2'd0;
    end
endmodule

// File: rtl/eg_core_chk.sv
// Property checker for eg_core, attached with bind. It watches the visit
// schedule, key events and the per-operator state registers.
module eg_core_chk #(
    parameter int NUM_OPS = 24,
    parameter int CNT_W   = 16,
    localparam int OP_W   = $clog2(NUM_OPS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      visit,
    input logic [OP_W-1:0]           op_idx,
    input logic [CNT_W-1:0]          env_cnt,
    input logic                      key_we,
    input logic [OP_W-1:0]           key_op,
    input logic                      key_on,
    input logic [NUM_OPS-1:0][9:0]   att_q,
    input logic [NUM_OPS-1:0][1:0]   ph_q
);
    logic last_visit;
    logic collide;
    assign last_visit = visit && (op_idx == OP_W'(NUM_OPS - 1));
    assign collide    = key_we && (key_op == op_idx);

    AST_VISIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        visit |=> !visit); // R10
    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        last_visit |=> env_cnt == $past(env_cnt) + 1'b1); // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_visit |=> $stable(env_cnt)); // R10
    AST_KEYOFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        key_we && !key_on && (int'(key_op) < NUM_OPS) |=> ph_q[$past(key_op)] == 2'd3); // R8
    AST_KEYON_START: assert property (@(posedge clk) disable iff (!rst_n)
        key_we && key_on && (int'(key_op) < NUM_OPS) |=> ph_q[$past(key_op)] <= 2'd1); // R7
    AST_ATTACK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        visit && !collide && ph_q[op_idx] == 2'd0 |=> att_q[$past(op_idx)] <= $past(att_q[op_idx])); // R5
    AST_CLIMB_UP: assert property (@(posedge clk) disable iff (!rst_n)
        visit && !collide && ph_q[op_idx] != 2'd0 |=> att_q[$past(op_idx)] >= $past(att_q[op_idx])); // R6
    AST_KEY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        visit && collide && !key_on |=> att_q[$past(op_idx)] == $past(att_q[op_idx])); // R9
endmodule

bind eg_core eg_core_chk #(.NUM_OPS(NUM_OPS), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .visit   (visit),
    .op_idx  (op_idx),
    .env_cnt (env_cnt),
    .key_we  (key_we),
    .key_op  (key_op),
    .key_on  (key_on),
    .att_q   (att_q),
    .ph_q    (ph_q)
);

// File: tb/eg_core_bench.sv
`timescale 1ns/10ps
module eg_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_op = '0, cfg_ar = '0, cfg_dr = '0, cfg_sr = '0, cfg_kc = '0;
    logic [3:0] cfg_rr = '0, cfg_sl = '0;
    logic [1:0] cfg_ks = '0;
    logic       key_we = 1'b0, key_on = 1'b0;
    logic [4:0] key_op = '0, rd_op = '0;
    logic [9:0] rd_att;
    logic [1:0] rd_phase;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    eg_core u_eg_core (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_ar(cfg_ar), .cfg_dr(cfg_dr), .cfg_sr(cfg_sr), .cfg_rr(cfg_rr),
        .cfg_sl(cfg_sl), .cfg_ks(cfg_ks), .cfg_kc(cfg_kc),
        .key_we(key_we), .key_op(key_op), .key_on(key_on),
        .rd_op(rd_op), .rd_att(rd_att), .rd_phase(rd_phase)
    );

    // ---------------- reference model ----------------
    int m_att [24], m_ph [24];
    int m_ar [24], m_dr [24], m_sr [24], m_rr [24], m_sl [24], m_ks [24], m_kc [24];
    int m_k, m_cnt;

    int lo_pat [4][8] = '{'{0,1,0,1,0,1,0,1}, '{0,1,0,1,1,1,0,1},
                          '{0,1,1,1,0,1,1,1}, '{0,1,1,1,1,1,1,1}};
    int hi_pat [4][8] = '{'{1,1,1,1,1,1,1,1}, '{1,1,1,2,1,1,1,2},
                          '{1,2,1,2,1,2,1,2}, '{1,2,2,2,1,2,2,2}};

    function automatic int b_eff(int r, int kc, int ks);
        int s;
        if (r == 0) return 0;
        s = 2 * r + (kc >> (3 - ks));
        return (s > 63) ? 63 : s;
    endfunction

    function automatic int b_inc(int e, int st);
        if (e < 2) return 0;
        if (e >= 60) return 8;
        if (e < 8) return (e >= 6) ? lo_pat[2][st] : lo_pat[0][st];
        if (e < 48) return lo_pat[e % 4][st];
        return hi_pat[e % 4][st] << ((e - 48) / 4);
    endfunction

    task automatic b_visit(int o);
        int ph, a, r, e, sh, inc, d, slv;
        ph = m_ph[o];
        a = m_att[o];
        slv = (m_sl[o] == 15) ? 1023 : m_sl[o] * 32;
        if (ph == 1 && a >= slv) ph = 2;
        case (ph)
            0: r = m_ar[o];
            1: r = m_dr[o];
            2: r = m_sr[o];
            default: r = 2 * m_rr[o] + 1;
        endcase
        e = b_eff(r, m_kc[o], m_ks[o]);
        sh = (e >= 48) ? 0 : (47 - e) / 4;
        if (m_cnt % (1 << sh) == 0) begin
            inc = b_inc(e, (m_cnt >> sh) % 8);
            if (ph == 0) begin
                d = ((a + 1) * inc + 15) / 16;
                if (d >= a) begin a = 0; ph = 1; end
                else a = a - d;
            end else begin
                a = a + inc;
                if (a > 1023) a = 1023;
            end
        end
        m_att[o] = a;
        m_ph[o] = ph;
    endtask

    always @(posedge clk) begin
        int vop, pre;
        if (!rst_n) begin
            for (int i = 0; i < 24; i++) begin
                m_att[i] = 1023; m_ph[i] = 3;
                m_ar[i] = 0; m_dr[i] = 0; m_sr[i] = 0; m_rr[i] = 0;
                m_sl[i] = 0; m_ks[i] = 0; m_kc[i] = 0;
            end
            m_k = 0; m_cnt = 0;
        end else begin
            vop = -1; pre = 0;
            if (m_k % 3 == 0) begin
                vop = (m_k / 3) % 24;
                pre = m_att[vop];
                b_visit(vop);
                if (vop == 23) m_cnt++;
            end
            if (key_we && key_op < 24) begin
                if (int'(key_op) == vop) m_att[vop] = pre;
                if (key_on && b_eff(m_ar[key_op], m_kc[key_op], m_ks[key_op]) >= 62) begin
                    m_att[key_op] = 0; m_ph[key_op] = 1;
                end else begin
                    m_ph[key_op] = key_on ? 0 : 3;
                end
            end
            if (cfg_we && cfg_op < 24) begin
                m_ar[cfg_op] = cfg_ar; m_dr[cfg_op] = cfg_dr; m_sr[cfg_op] = cfg_sr;
                m_rr[cfg_op] = cfg_rr; m_sl[cfg_op] = cfg_sl; m_ks[cfg_op] = cfg_ks;
                m_kc[cfg_op] = cfg_kc;
            end
            m_k++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic peek(int op);
        rd_op = 5'(op);
        #0.1;
    endtask

    task automatic cfg_write(int op, int ar, int dr, int sr, int rr, int sl, int ks, int kc);
        @(negedge clk);
        cfg_we = 1; cfg_op = 5'(op); cfg_ar = 5'(ar); cfg_dr = 5'(dr); cfg_sr = 5'(sr);
        cfg_rr = 4'(rr); cfg_sl = 4'(sl); cfg_ks = 2'(ks); cfg_kc = 5'(kc);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic key(int op, bit on);
        @(negedge clk);
        key_we = 1; key_op = 5'(op); key_on = on;
        @(negedge clk);
        key_we = 0;
    endtask

    task automatic expect_op(string tag, int op, int att, int ph);
        peek(op);
        chk({tag, " att"}, int'(rd_att), att);
        chk({tag, " phase"}, int'(rd_phase), ph);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int pre;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state of every operator.
        for (int o = 0; o < 24; o++) begin
            @(negedge clk);
            expect_op("R1 reset", o, 1023, 3);
        end

        // R11: cleared config means attack rate 0, so key-on enters attack.
        key(0, 1);
        expect_op("R11 cleared cfg keyon", 0, 1023, 0);

        // R2/R7: key scaling decides whether attack is skipped.
        cfg_write(5, 30, 0, 0, 0, 15, 3, 2);   // 60+2 = 62 -> skip
        key(5, 1);
        expect_op("R7 R2 skip ks3", 5, 0, 1);
        cfg_write(6, 30, 0, 0, 0, 15, 3, 1);   // 61 -> attack
        key(6, 1);
        expect_op("R7 R2 attack ks3", 6, 1023, 0);
        cfg_write(7, 30, 0, 0, 0, 15, 0, 31);  // 60+3 = 63 -> skip
        key(7, 1);
        expect_op("R2 skip ks0", 7, 0, 1);
        cfg_write(8, 30, 0, 0, 0, 15, 1, 8);   // 60+2 -> skip
        key(8, 1);
        expect_op("R2 skip ks1", 8, 0, 1);
        cfg_write(9, 30, 0, 0, 0, 15, 0, 8);   // 60+1 -> attack
        key(9, 1);
        expect_op("R11 R2 attack ks0", 9, 1023, 0);

        // R4/R10: rate 63 climbs by 8 on each of the 5 visits in 360 edges.
        cfg_write(10, 31, 31, 0, 0, 15, 3, 31);
        key(10, 1);
        expect_op("R7 fast keyon", 10, 0, 1);
        repeat (360) @(negedge clk);
        expect_op("R4 R10 inc8 x5", 10, 40, 1);
        // R6: saturates at 1023, then hands over to sustain.
        repeat (9360) @(negedge clk);
        expect_op("R6 saturate", 10, 1023, 2);

        // R6: sustain level sl=1 (32) stops decay; sustain rate 0 holds.
        cfg_write(11, 31, 31, 0, 15, 1, 3, 31);
        key(11, 1);
        repeat (360) @(negedge clk);
        expect_op("R6 sustain level", 11, 32, 2);
        // R8: key-off keeps attenuation, release rate 2*15+1 -> 63 -> +8.
        key(11, 0);
        expect_op("R8 keyoff", 11, 32, 3);
        repeat (72) @(negedge clk);
        expect_op("R8 release step", 11, 40, 3);

        // R9: key-off on the very edge that visits operator 12.
        cfg_write(12, 31, 31, 0, 0, 15, 3, 31);
        key(12, 1);
        repeat (200) @(negedge clk);
        while (!(m_k % 3 == 0 && (m_k / 3) % 24 == 12)) @(negedge clk);
        peek(12);
        pre = int'(rd_att);
        chk("R9 precondition climbing", int'(pre > 0 && pre < 1000), 1);
        key_we = 1; key_op = 5'd12; key_on = 0;
        @(negedge clk);
        key_we = 0;
        expect_op("R9 key beats visit", 12, pre, 3);

        // Random phase against the model.
        for (int c = 0; c < 40000; c++) begin
            int o;
            @(negedge clk);
            cfg_we = 0; key_we = 0;
            if ($urandom_range(0, 7) == 0) begin
                cfg_we = 1; cfg_op = 5'($urandom_range(0, 23));
                cfg_ar = 5'($urandom); cfg_dr = 5'($urandom); cfg_sr = 5'($urandom);
                cfg_rr = 4'($urandom); cfg_sl = 4'($urandom); cfg_ks = 2'($urandom);
                cfg_kc = 5'($urandom);
            end
            if ($urandom_range(0, 5) == 0) begin
                key_we = 1; key_op = 5'($urandom_range(0, 23)); key_on = 1'($urandom);
            end
            o = $urandom_range(0, 23);
            peek(o);
            case (m_ph[o])
                0: chk("R5 R3 model attack", int'(rd_att), m_att[o]);
                1, 2: chk("R6 R4 model decay/sustain", int'(rd_att), m_att[o]);
                default: chk("R8 R2 model release", int'(rd_att), m_att[o]);
            endcase
            chk("R10 R9 model phase", int'(rd_phase), m_ph[o]);
        end
        cfg_we = 0; key_we = 0;
        @(negedge clk);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule